// File: doc/BRIEF.md
# Programmable-Resolution Angle Tracking Loop

This block turns sampled sine and cosine amplitudes from a resolver into a 16-bit binary angle and a signed velocity word. A type-II digital loop holds an estimate φ of the shaft angle θ. On every sample strobe it forms the error sin θ·cos φ − cos θ·sin φ from a generated sine table with linear interpolation. The error feeds a saturating velocity integrator and a phase accumulator that wraps modulo one turn. The signed error is also brought out so that separate fault logic can watch the loop.

The output resolution is chosen at run time as 10, 12, 14 or 16 bits. The phase step per sample is multiplied by 2^(16−N), so a coarse setting tracks fast and a fine setting tracks accurately. An error near zero while the estimate sits on the far side of the circle is a false null. The loop detects it and pushes the velocity integrator off it, so a sudden half-turn step never leaves the loop stuck.

Top module: `tracking_rdc`

## Requirements
- R1: A synchronous reset clears the angle, velocity and error outputs to zero.
- R2: With a constant input angle, the angle output settles to within 96 + 2^(16−N) counts of 16-bit angle, modulo one turn, at every resolution N.
- R3: The resolution code res_sel values 0, 1, 2, 3 select N = 10, 12, 14, 16. The angle is left-aligned, and its lowest 16−N bits read zero.
- R4: In a clock cycle without smp_valid, angle, velocity and error keep their values, whatever the inputs and res_sel do.
- R5: The error is (sin_in·cos φ − cos_in·sin φ) / 2048, rounded toward minus infinity, with a table amplitude of 2047. At φ = 0 it is floor(sin_in·2047/2048).
- R6: For an input turning at a constant rate of r counts per sample, the velocity output settles to 512·r/2^(16−N), within 15 %.
- R7: On each sample the velocity gains the new error. The 24-bit phase (16 angle bits over 8 fraction bits) gains (velocity_old/2 + 16·error)·2^(16−N). The angle output is the top 16 phase bits, masked to N bits.
- R8: After an instantaneous 180° input step, including a step from reset to exactly 180°, the loop converges to the new angle within R2's tolerance.
- R9: The velocity integrator saturates at its signed limits and never wraps. With a 12-bit velocity, two samples at a 90° error give 2047, and at a 270° error give −2048.
- R10: The phase wraps modulo 2^16 angle counts. A constant rotation that passes through zero is tracked without disturbance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe; the loop advances one step when high |
| sin_in | input | IN_W | Signed sine amplitude sample |
| cos_in | input | IN_W | Signed cosine amplitude sample |
| res_sel | input | 2 | Resolution code: 0=10, 1=12, 2=14, 3=16 bits |
| angle_o | output | 16 | Left-aligned binary angle, full turn = 2^16 |
| vel_o | output | VEL_W | Signed velocity integrator |
| err_o | output | IN_W+2 | Signed loop error of the last sample |

## Verification
A wrong table entry, interpolation term or error sign appears at the ports as a static angle offset or a loop that runs away. It shows on the error output at the first strobe and on the angle within a few hundred samples. A wrong phase-step scaling or integrator update shows in the exact values after the first strobe after reset. A missing saturation shows as a sign flip of the velocity after two samples. A missing false-null kick leaves the angle frozen at zero after a 180° step, for as long as the input stays there.

// File: rtl/tracking_rdc.sv
module tracking_rdc #(
  parameter int IN_W     = 12,
  parameter int TW       = 12,
  parameter int LUT_BITS = 8,
  parameter int FRAC     = 8,
  parameter int VEL_W    = 20,
  parameter int KP_SH    = 4,
  parameter int KICK     = 256,
  parameter int NULL_TH  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_valid,
  input  logic signed [IN_W-1:0]  sin_in,
  input  logic signed [IN_W-1:0]  cos_in,
  input  logic [1:0]              res_sel,
  output logic [15:0]             angle_o,
  output logic signed [VEL_W-1:0] vel_o,
  output logic signed [IN_W+1:0]  err_o
);
  localparam int ERR_W = IN_W + 2;
  localparam int PH_W  = 16 + FRAC;
  localparam int LUT_N = 1 << LUT_BITS;
  localparam int HALF  = LUT_N / 2;
  localparam int FR_W  = 16 - LUT_BITS;
  localparam int AMP   = (1 << (TW - 1)) - 1;
  localparam int MW    = 48;
  localparam int SW    = 32;
  localparam int ISH   = 10 + LUT_BITS + FR_W;
  localparam int VW2   = VEL_W + 2;
  localparam logic signed [MW-1:0]    ICOEF = 48'sd6434;
  localparam logic signed [MW-1:0]    ZW    = '0;
  localparam logic signed [ERR_W-1:0] NTH   = ERR_W'(NULL_TH);
  localparam logic signed [VW2-1:0]   VMAX  = VW2'((1 << (VEL_W - 1)) - 1);
  localparam logic signed [VW2-1:0]   VMIN  = -VMAX - VW2'(1);
  localparam logic signed [VW2-1:0]   KW    = VW2'(KICK);
  localparam logic signed [VW2-1:0]   KLIM  = VMAX - VW2'(KICK) - VW2'(NULL_TH);
  localparam logic [LUT_BITS-1:0]     QTR   = LUT_BITS'(LUT_N / 4);

  function automatic longint lut_sin(input int k);
    longint kk, p, den, sg;
    kk = k;
    sg = 1;
    if (kk >= HALF) begin
      kk = kk - HALF;
      sg = -1;
    end
    p   = kk * (HALF - kk);
    den = 5 * HALF * HALF - 4 * p;
    return sg * ((16 * AMP * p + den / 2) / den);
  endfunction

  logic signed [TW-1:0] sin_lut [LUT_N];
  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    assign sin_lut[g] = TW'(lut_sin(g));
  end

  logic [PH_W-1:0]        phase_q, phase_nxt;
  logic signed [VEL_W-1:0] vel_q;
  logic signed [ERR_W-1:0] err_q, e_now;
  logic [15:0]            angle_q;
  logic [LUT_BITS-1:0]    idx;
  logic [FR_W-1:0]        fr;
  logic [2:0]             sh;
  logic signed [MW-1:0]   s0w, c0w, frw, sin_f, cos_f, sinw, cosw, dot;
  logic signed [SW-1:0]   step;
  logic signed [VW2-1:0]  vsum;
  logic signed [VEL_W-1:0] vel_nxt;
  logic                   fnull;

  assign idx  = phase_q[PH_W-1 -: LUT_BITS];
  assign fr   = phase_q[PH_W-1-LUT_BITS -: FR_W];
  assign sh   = {~res_sel, 1'b0};
  assign s0w  = MW'(sin_lut[idx]);
  assign c0w  = MW'(sin_lut[idx + QTR]);
  assign frw  = $signed(MW'(fr));
  assign sinw = MW'(sin_in);
  assign cosw = MW'(cos_in);

  assign sin_f = s0w + ((c0w * frw * ICOEF) >>> ISH);
  assign cos_f = c0w - ((s0w * frw * ICOEF) >>> ISH);
  assign e_now = ERR_W'((sinw * cos_f - cosw * sin_f) >>> (TW - 1));
  assign dot   = sinw * sin_f + cosw * cos_f;
  assign fnull = (dot < ZW) && (e_now < NTH) && (e_now > -NTH);

  assign vsum = VW2'(vel_q) + VW2'(e_now) + (fnull ? KW : '0);
  always_comb begin
    if (vsum > VMAX)      vel_nxt = VEL_W'(VMAX);
    else if (vsum < VMIN) vel_nxt = VEL_W'(VMIN);
    else                  vel_nxt = VEL_W'(vsum);
  end

  assign step      = ((SW'(vel_q) >>> 1) + (SW'(e_now) <<< KP_SH)) <<< sh;
  assign phase_nxt = phase_q + PH_W'(step);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      vel_q   <= '0;
      err_q   <= '0;
      angle_q <= '0;
    end else if (smp_valid) begin
      phase_q <= phase_nxt;
      vel_q   <= vel_nxt;
      err_q   <= e_now;
      angle_q <= phase_nxt[PH_W-1 -: 16] & (16'hFFFF << sh);
    end
  end

  assign angle_o = angle_q;
  assign vel_o   = vel_q;
  assign err_o   = err_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (angle_o == 16'd0 && vel_o == '0 && err_o == '0)); // R1
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!$past(smp_valid) && !$past(rst)) |-> ($stable(angle_o) && $stable(vel_o) && $stable(err_o))); // R4
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(smp_valid) && $past(res_sel) == 2'd0) |-> (angle_o[5:0] == 6'd0)); // R3
  AST_VEL_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    ($past(smp_valid) && !$past(rst) && VW2'($past(vel_q)) == VMAX && $past(e_now) >= 0)
      |-> (VW2'(vel_q) == VMAX)); // R9
  AST_KICK_RAISES: assert property (@(posedge clk) disable iff (rst)
    ($past(smp_valid) && !$past(rst) && $past(fnull) && VW2'($past(vel_q)) < KLIM)
      |-> (vel_q > $past(vel_q))); // R8
endmodule

// File: tb/tracking_rdc_bench.sv
module tracking_rdc_bench;
  localparam int CLK_P = 10;
  localparam real AMPL = 1600.0;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic signed [11:0] sin_i = '0;
  logic signed [11:0] cos_i = '0;
  logic [1:0] res = 2'd3;
  logic [15:0] ang, ang_s;
  logic signed [19:0] vel;
  logic signed [11:0] vel_s;
  logic signed [13:0] err, err_s;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tracking_rdc u_tracking_rdc (
    .clk(clk), .rst(rst), .smp_valid(vld), .sin_in(sin_i), .cos_in(cos_i),
    .res_sel(res), .angle_o(ang), .vel_o(vel), .err_o(err));

  tracking_rdc #(.VEL_W(12)) u_tracking_rdc_sat (
    .clk(clk), .rst(rst), .smp_valid(vld), .sin_in(sin_i), .cos_in(cos_i),
    .res_sel(res), .angle_o(ang_s), .vel_o(vel_s), .err_o(err_s));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int adiff(input int a, input int b);
    int d = (a - b) & 16'hFFFF;
    if (d >= 32768) d = d - 65536;
    return (d < 0) ? -d : d;
  endfunction

  function automatic int tol(input int rs);
    return 96 + (1 << (6 - 2 * rs));
  endfunction

  task automatic set_ang(input int th);
    real a = TWO_PI * real'(th & 16'hFFFF) / 65536.0;
    sin_i = 12'(rnd(AMPL * $sin(a)));
    cos_i = 12'(rnd(AMPL * $cos(a)));
  endtask

  task automatic do_reset();
    vld = 1'b0;
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic settle(input int th, input int n, input string tag);
    set_ang(th);
    vld = 1'b1;
    repeat (n) tick();
    chk(adiff(int'(ang), th) <= tol(int'(res)), tag, int'(ang), th & 16'hFFFF);
    chk((int'(ang) & ((1 << (6 - 2 * int'(res))) - 1)) == 0, "R3 low bits", int'(ang), 0);
  endtask

  initial begin
    int e_exp, p, a_exp, th, pa, pv, pe, v, rs;
    void'($urandom(32'd4242));
    do_reset();
    chk(ang == 16'd0, "R1 angle", int'(ang), 0);
    chk(vel == '0, "R1 velocity", int'(vel), 0);
    chk(err == '0, "R1 error", int'(err), 0);

    // first sample after reset at 90 deg, 16-bit: exact values
    res = 2'd3;
    sin_i = 12'sd1600;
    cos_i = 12'sd0;
    vld = 1'b1;
    tick();
    e_exp = (1600 * 2047) >>> 11;
    chk(int'(err) == e_exp, "R5 error at phase 0", int'(err), e_exp);
    chk(int'(vel) == e_exp, "R7 velocity first step", int'(vel), e_exp);
    chk(int'(ang) == ((e_exp * 16) >> 8), "R7 angle first step", int'(ang), (e_exp * 16) >> 8);
    tick();
    chk(int'(vel_s) == 2047, "R9 positive limit", int'(vel_s), 2047);
    tick();
    tick();
    chk(int'(vel_s) == 2047, "R9 stays at limit", int'(vel_s), 2047);

    do_reset();
    sin_i = -12'sd1600;
    cos_i = 12'sd0;
    vld = 1'b1;
    tick();
    tick();
    chk(int'(vel_s) == -2048, "R9 negative limit", int'(vel_s), -2048);

    // first-step exactness for random inputs at every resolution
    for (int i = 0; i < 8; i++) begin
      do_reset();
      rs = i % 4;
      res = 2'(rs);
      sin_i = 12'($urandom_range(3200) - 1600);
      cos_i = 12'($urandom_range(3200) - 1600);
      vld = 1'b1;
      tick();
      vld = 1'b0;
      e_exp = (int'(sin_i) * 2047) >>> 11;
      p = ((e_exp * 16) << (6 - 2 * rs)) & 24'hFFFFFF;
      a_exp = (p >> 8) & ((16'hFFFF << (6 - 2 * rs)) & 16'hFFFF);
      chk(int'(err) == e_exp, "R5 random error", int'(err), e_exp);
      chk(int'(ang) == a_exp, "R7 random step", int'(ang), a_exp);
    end

    // static convergence at each resolution
    for (int r = 0; r < 4; r++) begin
      do_reset();
      res = 2'(r);
      for (int k = 0; k < 3; k++) begin
        th = int'($urandom_range(65535));
        settle(th, 3000, "R2 static angle");
      end
    end

    // false null: reset at 0 then exactly 180 deg, then MSB toggled back
    do_reset();
    res = 2'd3;
    settle(32768, 6000, "R8 half-turn from reset");
    settle(0, 6000, "R8 half-turn back");
    do_reset();
    res = 2'd0;
    settle(32768, 2000, "R8 half-turn coarse");

    // constant rate at 16 bits, crossing zero
    do_reset();
    res = 2'd3;
    vld = 1'b1;
    th = 51536;
    for (int i = 0; i < 4000; i++) begin
      set_ang(th);
      tick();
      if (i == 2999) begin
        chk(int'(vel) > 1740 && int'(vel) < 2356, "R6 velocity 16-bit", int'(vel), 2048);
        chk(adiff(int'(ang), th) <= tol(3), "R10 tracking before wrap", int'(ang), th & 16'hFFFF);
      end
      if (i == 3900) begin
        chk(adiff(int'(ang), th) <= tol(3), "R10 tracking after wrap", int'(ang), th & 16'hFFFF);
        chk(int'(vel) > 1740 && int'(vel) < 2356, "R10 velocity after wrap", int'(vel), 2048);
      end
      th = (th + 4) & 16'hFFFF;
    end

    // constant rate at 12 bits
    do_reset();
    res = 2'd1;
    vld = 1'b1;
    th = 1000;
    for (int i = 0; i < 2000; i++) begin
      set_ang(th);
      tick();
      th = (th + 64) & 16'hFFFF;
    end
    chk(int'(vel) > 1740 && int'(vel) < 2356, "R6 velocity 12-bit", int'(vel), 2048);

    // random strobes: outputs hold without smp_valid
    for (int i = 0; i < 200; i++) begin
      pa = int'(ang);
      pv = int'(vel);
      pe = int'(err);
      v = int'($urandom_range(1));
      vld = v[0];
      rs = int'($urandom_range(3));
      res = 2'(rs);
      set_ang(int'($urandom_range(65535)));
      tick();
      if (v == 0) begin
        chk(int'(ang) == pa, "R4 angle hold", int'(ang), pa);
        chk(int'(vel) == pv && int'(err) == pe, "R4 velocity/error hold", int'(vel), pv);
      end else begin
        chk((int'(ang) & ((1 << (6 - 2 * rs)) - 1)) == 0, "R3 random low bits", int'(ang), 0);
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule